// File: doc/BRIEF.md
# Page-Chained Cycle-Stealing DMA Engine

This block is a bus-master transfer engine that moves words between a peripheral and memory while the CPU gets on with other work. Software programs a start word address, a word count and a direction through a small write-only register port, loads up to four page numbers into a chain list, and then sets the go bit. From then on the engine moves one word in each cycle that meets three conditions. The CPU must have left the memory port idle in that cycle. In device-to-memory mode the peripheral must be presenting data. In memory-to-device mode the peripheral must be ready to take data.

Memory is viewed in pages of 256 words. The start address picks the first page and the offset inside it. The offset then counts up by one per word. When the offset runs off the end of a page, the engine does not step into the next page in sequence. It takes the next page number from the chain list instead, so a buffer made of scattered physical pages can be handled as one transfer. When the count is used up, the engine goes idle and raises an interrupt. The interrupt holds until software clears it.

Top module: `dma_page_chain`

## Requirements
- R1: After reset, `busy`, `irq`, `mem_req`, `dev_rx_ack` and `dev_tx_strobe` are all low.
- R2: Register writes use `cfg_addr`. Register 0 holds the start word address. Register 1 holds the word count. In register 2, bit 0 is the direction (1 means memory to device) and bit 1 is go. A write of register 2 with go set while idle starts a transfer, and `busy` is high from the following cycle.
- R3: In device-to-memory mode a word moves only in a cycle where `dev_rx_req` is high. In that same cycle `mem_req`, `mem_we` and `dev_rx_ack` are high and `mem_wdata` equals `dev_rx_data`.
- R4: In memory-to-device mode a word moves only in a cycle where `dev_tx_ready` is high. In that same cycle `mem_req` and `dev_tx_strobe` are high, `mem_we` is low, and `dev_tx_data` equals `mem_rdata`.
- R5: `mem_req` is never high in a cycle where `cpu_bus_busy` is high.
- R6: Inside a page, each word goes to the address one above the previous word's address. The first word goes to the start address.
- R7: After a word at page offset 255, the next address is the chain entry times 256, with offset 0. Chain entries are written at register 4+k, page number in the low 8 bits. The first crossing uses entry 0 and each later crossing uses the next entry, wrapping from entry 3 back to entry 0.
- R8: Exactly as many words move as the count asked for. In the cycle after the last word, `busy` is low and `irq` is high.
- R9: A start with a count of zero makes no memory access. It gives `irq` high and `busy` low in the next cycle.
- R10: `irq` stays high until register 3 is written with bit 0 set. It is low from the next cycle. If completion and the clear happen in the same cycle, completion wins.
- R11: While `busy` is high, writes to registers 0, 1, 2 and the chain entries are ignored. The running transfer is not restarted or changed, and the earlier settings are still in place for the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 16 | Register write data |
| cpu_bus_busy | input | 1 | CPU is using the memory port this cycle |
| mem_req | output | 1 | Engine is using the memory port this cycle |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |
| dev_rx_req | input | 1 | Peripheral has a word for memory |
| dev_rx_data | input | 16 | Word from the peripheral |
| dev_rx_ack | output | 1 | Peripheral word taken this cycle |
| dev_tx_ready | input | 1 | Peripheral can take a word |
| dev_tx_strobe | output | 1 | Word offered to the peripheral this cycle |
| dev_tx_data | output | 16 | Word to the peripheral |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt, held until cleared |

## Verification
Both directions are run twice: once with the CPU never holding the bus and the peripheral always willing, and once with all three gating inputs changed by a pseudo-random sequence. The first run shows the exact one-word-per-cycle pacing. The second run shows that a stalled cycle never moves or skips a word. Start points just before a page end, and a transfer longer than four pages, separate sequential page stepping from chain stepping, and show whether the chain wraps correctly. A zero count, writes made in the middle of a transfer and then followed by a start that reuses the old settings, and a delayed interrupt clear show the difference between settings that were latched and settings that were ignored.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // register indices on the configuration port
  localparam int REG_BASE  = 0;
  localparam int REG_COUNT = 1;
  localparam int REG_CTRL  = 2;
  localparam int REG_STAT  = 3;
  localparam int REG_CHAIN = 4;

  localparam int CTRL_DIR_BIT = 0;
  localparam int CTRL_GO_BIT  = 1;
  localparam int STAT_CLR_BIT = 0;

  // place a page number above an in-page offset
  function automatic logic [31:0] join_addr(input logic [31:0] page,
                                            input logic [31:0] off,
                                            input int obits);
    return (page << obits) | off;
  endfunction

  // true when the offset is the last word of its page
  function automatic logic at_page_end(input logic [31:0] off, input int obits);
    return off == ((32'd1 << obits) - 32'd1);
  endfunction

  // step through the chain list, wrapping after the last entry
  function automatic logic [31:0] next_index(input logic [31:0] idx, input int n);
    return (idx == 32'(n - 1)) ? 32'd0 : idx + 32'd1;
  endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int AW     = 16,
  parameter int RAW    = 3,
  parameter int NCHAIN = 4,
  parameter int PW     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [RAW-1:0]             cfg_addr,
  input  logic [AW-1:0]              cfg_wdata,
  input  logic                       busy,
  input  logic                       done_ev,
  output logic [AW-1:0]              start_addr,
  output logic [AW-1:0]              xfer_len,
  output logic                       dir,
  output logic [NCHAIN-1:0][PW-1:0]  chain,
  output logic                       start_ev,
  output logic                       irq
);
  logic open_wr;
  logic clr_hit;

  assign open_wr  = cfg_we && !busy;
  assign start_ev = open_wr && (cfg_addr == RAW'(dma_pkg::REG_CTRL))
                    && cfg_wdata[dma_pkg::CTRL_GO_BIT];
  assign clr_hit  = cfg_we && (cfg_addr == RAW'(dma_pkg::REG_STAT))
                    && cfg_wdata[dma_pkg::STAT_CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_addr <= '0;
      xfer_len   <= '0;
      dir        <= 1'b0;
      chain      <= '0;
    end else if (open_wr) begin
      if (cfg_addr == RAW'(dma_pkg::REG_BASE))  start_addr <= cfg_wdata;
      if (cfg_addr == RAW'(dma_pkg::REG_COUNT)) xfer_len   <= cfg_wdata;
      if (cfg_addr == RAW'(dma_pkg::REG_CTRL))  dir        <= cfg_wdata[dma_pkg::CTRL_DIR_BIT];
      for (int k = 0; k < NCHAIN; k++) begin
        if (cfg_addr == RAW'(dma_pkg::REG_CHAIN + k)) chain[k] <= cfg_wdata[PW-1:0];
      end
    end
  end

  // completion has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)       irq <= 1'b0;
    else if (done_ev) irq <= 1'b1;
    else if (clr_hit) irq <= 1'b0;
  end

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_hit) |=> irq);

  // R11
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && cfg_addr != RAW'(dma_pkg::REG_STAT)) |=>
    ($stable(start_addr) && $stable(xfer_len) && $stable(dir) && $stable(chain)));
endmodule

// File: rtl/dma_seg.sv
module dma_seg #(
  parameter int AW     = 16,
  parameter int OB     = 8,
  parameter int NCHAIN = 4,
  parameter int PW     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_ev,
  input  logic [AW-1:0]              start_addr,
  input  logic [AW-1:0]              xfer_len,
  input  logic [NCHAIN-1:0][PW-1:0]  chain,
  input  logic                       move,
  output logic                       active,
  output logic [AW-1:0]              mem_addr,
  output logic                       done_ev
);
  localparam int IW = (NCHAIN > 1) ? $clog2(NCHAIN) : 1;

  logic [PW-1:0] page_q;
  logic [OB-1:0] off_q;
  logic [AW-1:0] remain_q;
  logic [IW-1:0] idx_q;
  logic          active_q;

  logic          page_end;
  logic          zero_start;
  logic          last_word;
  logic [PW-1:0] next_page;
  logic [IW-1:0] idx_nxt;

  assign page_end   = dma_pkg::at_page_end(32'(off_q), OB);
  assign next_page  = chain[idx_q];
  assign idx_nxt    = IW'(dma_pkg::next_index(32'(idx_q), NCHAIN));
  assign zero_start = start_ev && (xfer_len == '0);
  assign last_word  = move && (remain_q == AW'(1));
  assign done_ev    = zero_start || last_word;
  assign active     = active_q;
  assign mem_addr   = AW'(dma_pkg::join_addr(32'(page_q), 32'(off_q), OB));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      off_q    <= '0;
      remain_q <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
    end else if (start_ev) begin
      page_q   <= start_addr[AW-1:OB];
      off_q    <= start_addr[OB-1:0];
      remain_q <= xfer_len;
      idx_q    <= '0;
      active_q <= (xfer_len != '0);
    end else if (move) begin
      off_q    <= off_q + OB'(1);
      remain_q <= remain_q - AW'(1);
      if (page_end) begin
        page_q <= next_page;
        idx_q  <= idx_nxt;
      end
      if (remain_q == AW'(1)) active_q <= 1'b0;
    end
  end

  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move && !page_end) |=> (mem_addr == $past(mem_addr) + AW'(1)));

  // R7
  hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move && page_end) |=> (mem_addr[AW-1:OB] == $past(next_page) && mem_addr[OB-1:0] == '0));

  // R8
  tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
    move |=> (remain_q == $past(remain_q) - AW'(1)));
endmodule

// File: rtl/dma_page_chain.sv
module dma_page_chain #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int PAGE_BITS = 8,
  parameter int NCHAIN    = 4,
  parameter int RAW       = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           cpu_bus_busy,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           dev_rx_req,
  input  logic [DW-1:0]  dev_rx_data,
  output logic           dev_rx_ack,
  input  logic           dev_tx_ready,
  output logic           dev_tx_strobe,
  output logic [DW-1:0]  dev_tx_data,
  output logic           busy,
  output logic           irq
);
  localparam int PW = AW - PAGE_BITS;

  logic                      active;
  logic                      start_ev;
  logic                      done_ev;
  logic                      dir;
  logic                      move;
  logic [AW-1:0]             start_addr;
  logic [AW-1:0]             xfer_len;
  logic [NCHAIN-1:0][PW-1:0] chain;

  dma_regs #(.AW(AW), .RAW(RAW), .NCHAIN(NCHAIN), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(active), .done_ev(done_ev),
    .start_addr(start_addr), .xfer_len(xfer_len), .dir(dir), .chain(chain),
    .start_ev(start_ev), .irq(irq)
  );

  dma_seg #(.AW(AW), .OB(PAGE_BITS), .NCHAIN(NCHAIN), .PW(PW)) u_seg (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .start_addr(start_addr),
    .xfer_len(xfer_len), .chain(chain), .move(move), .active(active),
    .mem_addr(mem_addr), .done_ev(done_ev)
  );

  // a word moves only on a cycle the CPU leaves idle and the peripheral allows
  assign move          = active && !cpu_bus_busy && (dir ? dev_tx_ready : dev_rx_req);
  assign mem_req       = move;
  assign mem_we        = move && !dir;
  assign mem_wdata     = dev_rx_data;
  assign dev_rx_ack    = move && !dir;
  assign dev_tx_strobe = move && dir;
  assign dev_tx_data   = mem_rdata;
  assign busy          = active;

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && xfer_len == '0) |=> (irq && !busy));

  // R8
  end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
endmodule

// File: tb/sim_dma_page_chain.sv
module sim_dma_page_chain;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          cpu_bus_busy = 1'b0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          dev_rx_req = 1'b0;
  logic [DW-1:0] dev_rx_data = 16'h1000;
  logic          dev_rx_ack;
  logic          dev_tx_ready = 1'b0;
  logic          dev_tx_strobe;
  logic [DW-1:0] dev_tx_data;
  logic          busy, irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_xfer_cyc = 0;
  int words_seen = 0;
  bit ack_seen = 0;
  bit stall = 0;
  bit cur_dir = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  chain_b [4] = '{8'h40, 8'h13, 8'h7F, 8'h02};
  logic [AW-1:0] exp_addr_q [$];
  logic [DW-1:0] exp_data_q [$];

  // 250 MHz: period of 4 time units (ns)
  always #2 clk = ~clk;

  function automatic logic [DW-1:0] mem_model(input logic [AW-1:0] a);
    return ~a ^ 16'h3C5A;
  endfunction
  assign mem_rdata = mem_model(mem_addr);

  dma_page_chain u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cpu_bus_busy(cpu_bus_busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_rx_req(dev_rx_req),
    .dev_rx_data(dev_rx_data), .dev_rx_ack(dev_rx_ack), .dev_tx_ready(dev_tx_ready),
    .dev_tx_strobe(dev_tx_strobe), .dev_tx_data(dev_tx_data), .busy(busy), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // input driver: a step after each rising edge
  task automatic drive_inputs();
    if (ack_seen) begin
      dev_rx_data = dev_rx_data + 16'd1;
      ack_seen = 0;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dev_rx_req   = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
    dev_tx_ready = stall ? (lfsr[1] | lfsr[6]) : 1'b1;
    cpu_bus_busy = stall ? (lfsr[2] & lfsr[4]) : 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    drive_inputs();
  end

  // monitor: pops the scoreboard at each falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_req && cpu_bus_busy) chk(0, "R5", "access while cpu busy", 1, 0);
      if (mem_req) begin
        last_xfer_cyc = cyc;
        words_seen++;
        if (exp_addr_q.size() == 0) begin
          chk(0, "R8", "extra word moved", 32'(mem_addr), 0);
        end else begin
          logic [AW-1:0] ea;
          logic [DW-1:0] ed;
          ea = exp_addr_q.pop_front();
          ed = exp_data_q.pop_front();
          chk(mem_addr == ea, "R6/R7", "address", 32'(mem_addr), 32'(ea));
          if (!cur_dir) begin
            chk(mem_we && dev_rx_ack && dev_rx_req, "R3", "write strobes",
                {mem_we, dev_rx_ack, dev_rx_req}, 3'b111);
            chk(mem_wdata == ed, "R3", "write data", 32'(mem_wdata), 32'(ed));
            if (dev_rx_ack) ack_seen = 1;
          end else begin
            chk(!mem_we && dev_tx_strobe && dev_tx_ready, "R4", "read strobes",
                {mem_we, dev_tx_strobe, dev_tx_ready}, 3'b011);
            chk(dev_tx_data == ed, "R4", "device data", 32'(dev_tx_data), 32'(ed));
          end
        end
      end else if (dev_rx_ack || dev_tx_strobe) begin
        chk(0, "R3", "handshake without memory cycle", {dev_rx_ack, dev_tx_strobe}, 0);
      end
    end
  end

  task automatic wait_neg();
    @(negedge clk);
    #1;
  endtask

  task automatic reg_wr(input int a, input logic [AW-1:0] d);
    @(posedge clk);
    #1;
    cfg_we = 1'b1;
    cfg_addr = 3'(a);
    cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  // driver: computes the expected words and pushes them to the scoreboard
  task automatic run_xfer(input logic [AW-1:0] start, input int len, input bit dir,
                          input bit stl, input bit poke, input bit reuse);
    logic [7:0] page;
    logic [8:0] off;
    int idx;
    int guard;
    page = start[15:8];
    off = {1'b0, start[7:0]};
    idx = 0;
    for (int i = 0; i < len; i++) begin
      logic [AW-1:0] a;
      a = {page, off[7:0]};
      exp_addr_q.push_back(a);
      exp_data_q.push_back(dir ? mem_model(a) : dev_rx_data + 16'(i));
      off = off + 9'd1;
      if (off == 9'd256) begin
        off = '0;
        page = chain_b[idx];
        idx = (idx + 1) % 4;
      end
    end
    cur_dir = dir;
    stall = stl;
    if (!reuse) begin
      reg_wr(0, start);
      reg_wr(1, 16'(len));
    end
    reg_wr(2, {14'd0, 1'b1, dir});
    chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
    if (poke) begin
      // R11: these must all be ignored
      reg_wr(1, 16'd7);
      reg_wr(0, 16'h0000);
      reg_wr(4, 16'h00EE);
      reg_wr(2, {14'd0, 1'b1, ~dir});
    end
    guard = 0;
    do begin
      wait_neg();
      guard++;
    end while (!irq && guard < 20000);
    chk(irq == 1'b1, "R8", "irq raised", 32'(irq), 1);
    chk(cyc == last_xfer_cyc + 1, "R8", "irq one cycle after last word", cyc, last_xfer_cyc + 1);
    chk(busy == 1'b0, "R8", "idle at end", 32'(busy), 0);
    chk(exp_addr_q.size() == 0, "R8", "words left over", exp_addr_q.size(), 0);
    stall = 0;
    repeat (4) wait_neg();
    chk(irq == 1'b1, "R10", "irq held", 32'(irq), 1);
    reg_wr(3, 16'd1);
    wait_neg();
    chk(irq == 1'b0, "R10", "irq cleared", 32'(irq), 0);
  endtask

  initial begin
    int w0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    wait_neg();
    // R1
    chk(!busy && !irq && !mem_req && !dev_rx_ack && !dev_tx_strobe, "R1", "reset state",
        {busy, irq, mem_req, dev_rx_ack, dev_tx_strobe}, 0);
    for (int k = 0; k < 4; k++) reg_wr(4 + k, {8'd0, chain_b[k]});

    run_xfer(16'h0310, 5, 0, 0, 0, 0);      // R3 plain device-to-memory
    run_xfer(16'h05FA, 300, 0, 1, 0, 0);    // R7 crossings with stalls
    run_xfer(16'h7FFE, 3, 0, 1, 0, 0);      // R7 crossing after two words
    run_xfer(16'h21F0, 40, 1, 1, 1, 0);     // R4 and R11 writes during transfer
    run_xfer(16'h21F0, 40, 1, 0, 0, 1);     // R11 settings kept for reuse
    run_xfer(16'h09FF, 1026, 1, 0, 0, 0);   // R7 chain wraps to entry 0

    // R9 zero count
    w0 = words_seen;
    reg_wr(1, 16'd0);
    reg_wr(2, 16'd2);
    wait_neg();
    chk(irq == 1'b1 && busy == 1'b0, "R9", "zero count completes", {irq, busy}, 2'b10);
    chk(words_seen == w0, "R9", "no access on zero count", words_seen, w0);
    reg_wr(3, 16'd1);
    wait_neg();
    chk(irq == 1'b0, "R10", "clear after zero count", 32'(irq), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #600000;
    chk(0, "R8", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule